// File: doc/BRIEF.md
# Graceful-Degradation Eight-Point Inverse DCT

This block computes a one-dimensional eight-point inverse discrete cosine transform without multipliers. Every constant product is a sum of shifted copies of the input, using a fixed set of seven 8-bit coefficients with seven fraction bits. Each spatial output is assembled from three partial sums that share no adders. The first is a DC term taken from coefficient 0 alone. The second is a mid-band term from coefficients 1 to 4. The third is a high-band term from coefficients 5 to 7. A three-way selector then picks how many of these terms reach the output.

Two quality bits choose one of three quality states for each vector: FULL, MID or DC. In FULL all three terms are summed. In MID the high-band term is dropped. In DC only the DC term is used. The state is decoded from the quality bits with these transitions: both bits low selects FULL. Only the drop bit high selects MID. The DC-only bit high selects DC, whatever the drop bit is. The state is captured together with its vector, so consecutive vectors may use different states.

The block has an input register stage and an output register stage. It accepts one vector per clock.

Top module: `idct_gd_top`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0 and out_pix is all zeros.
- R2: A vector presented with in_valid high at one rising edge appears on out_pix, with out_valid high, after the next rising edge. out_valid stays high for exactly one cycle per accepted vector. A new vector can be accepted on every cycle.
- R3: In FULL (drop_hi=0, dc_only=0), output w_i is the rounded value of sum over k of M[i][k]*z_k/128. Row w0 of M is (45,64,60,52,45,36,25,12). The coefficients are a=64, b=60, c=52, d=45, e=36, f=25, g=12, placed and signed as in the standard cosine basis. Row w(7-i) equals row w(i) with the odd-k entries negated.
- R4: In MID (drop_hi=1, dc_only=0), z5, z6 and z7 are left out of the sum. z0 to z4 still contribute as in R3.
- R5: In DC (dc_only=1, with any value of drop_hi), all eight outputs equal the rounded value of 45*z0/128.
- R6: Rounding is (S + 64) >> 7, an arithmetic shift, so ties go toward plus infinity. For example, S=64 gives 1 and S=-64 gives 0.
- R7: When no vector was accepted in the previous cycle, out_pix keeps its value and out_valid is 0, whatever in_coef and the quality bits hold.
- R8: The quality bits are sampled with the vector they accompany. Back-to-back vectors with different quality states are each transformed in their own state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector qualifier |
| in_coef | input | 96 | Coefficients z0..z7, each 12-bit signed; z_k is at bits [12k+11:12k] |
| drop_hi | input | 1 | Drop the high-band term (MID) |
| dc_only | input | 1 | Keep only the DC term (DC); takes priority over drop_hi |
| out_valid | output | 1 | Output vector qualifier |
| out_pix | output | 128 | Outputs w0..w7, each 16-bit signed; w_i is at bits [16i+15:16i] |

## Verification
A single coefficient of value 128 is applied on each index in turn. This gives one column of the basis per vector, so a wrong sign, a misplaced coefficient or a broken mirror shows up in a single output. A dense mixed-sign vector is then sent back to back in FULL, MID, DC and both-bits-high. This separates the three terms from each other, checks the priority of dc_only, and checks that the quality state travels with its vector. Full-scale vectors test the widths. Inputs of plus or minus 1 and plus or minus 2 test the rounding ties, and a quiet interval shows that the outputs hold.

// File: rtl/idct_gd_pkg.sv
package idct_gd_pkg;

    localparam int COEF_W = 8;
    localparam int FRAC_W = 7;
    localparam int NPT    = 8;
    localparam int HALF   = NPT / 2;

    typedef enum logic [1:0] {
        Q_FULL = 2'd0,
        Q_MID  = 2'd1,
        Q_DC   = 2'd2
    } quality_e;

    localparam logic [COEF_W-1:0] K_A = 8'b0100_0000;
    localparam logic [COEF_W-1:0] K_B = 8'b0011_1100;
    localparam logic [COEF_W-1:0] K_C = 8'b0011_0100;
    localparam logic [COEF_W-1:0] K_D = 8'b0010_1101;
    localparam logic [COEF_W-1:0] K_E = 8'b0010_0100;
    localparam logic [COEF_W-1:0] K_F = 8'b0001_1001;
    localparam logic [COEF_W-1:0] K_G = 8'b0000_1100;

    function automatic logic [COEF_W-1:0] cos_mag(input int m);
        case (m)
            1: return K_A;
            2: return K_B;
            3: return K_C;
            4: return K_D;
            5: return K_E;
            6: return K_F;
            7: return K_G;
            default: return '0;
        endcase
    endfunction

    // Angle index (2i+1)k mod 32 folded into the first quadrant.
    function automatic int fold_idx(input int i, input int k);
        int m;
        m = ((2 * i + 1) * k) % 32;
        if (k == 0)  return 4;
        if (m < 8)   return m;
        if (m < 16)  return 16 - m;
        if (m < 24)  return m - 16;
        return 32 - m;
    endfunction

    function automatic bit fold_neg(input int i, input int k);
        int m;
        m = ((2 * i + 1) * k) % 32;
        if (k == 0) return 1'b0;
        return (m > 8) && (m < 24);
    endfunction

endpackage

// File: rtl/idct_gd_cmul.sv
module idct_gd_cmul
    import idct_gd_pkg::*;
#(
    parameter int                IN_W  = 12,
    parameter int                ACC_W = 23,
    parameter logic [COEF_W-1:0] COEF  = K_D
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [ACC_W-1:0] p
);

    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] part [COEF_W];
    logic signed [ACC_W-1:0] kw;

    assign xe = ACC_W'(x);
    assign kw = ACC_W'(COEF);

    for (genvar b = 0; b < COEF_W; b++) begin : g_bit
        if (COEF[b]) begin : g_on
            assign part[b] = xe <<< b;
        end else begin : g_off
            assign part[b] = '0;
        end
    end

    always_comb begin
        p = '0;
        for (int j = 0; j < COEF_W; j++) begin
            p = p + part[j];
        end
    end

    // R3
    always_comb begin
        if (!$isunknown(x)) begin
            mul_match_chk: assert (p == xe * kw);
        end
    end

endmodule

// File: rtl/idct_gd_lane.sv
module idct_gd_lane
    import idct_gd_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int ACC_W = 23,
    parameter int IDX   = 0
) (
    input  logic [NPT*IN_W-1:0]     z,
    output logic signed [ACC_W-1:0] t1,
    output logic signed [ACC_W-1:0] t2e,
    output logic signed [ACC_W-1:0] t2o,
    output logic signed [ACC_W-1:0] t3e,
    output logic signed [ACC_W-1:0] t3o
);

    logic signed [ACC_W-1:0] pr   [NPT];
    logic signed [ACC_W-1:0] cont [NPT];

    for (genvar k = 0; k < NPT; k++) begin : g_tap
        localparam logic [COEF_W-1:0] CK  = cos_mag(fold_idx(IDX, k));
        localparam bit                NEG = fold_neg(IDX, k);

        idct_gd_cmul #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W),
            .COEF  (CK)
        ) u_mul (
            .x (z[k*IN_W +: IN_W]),
            .p (pr[k])
        );

        if (NEG) begin : g_neg
            assign cont[k] = -pr[k];
        end else begin : g_pos
            assign cont[k] = pr[k];
        end
    end

    // Three groups, no adder shared between them.
    assign t1  = cont[0];
    assign t2e = cont[2] + cont[4];
    assign t2o = cont[1] + cont[3];
    assign t3e = cont[6];
    assign t3o = cont[5] + cont[7];

endmodule

// File: rtl/idct_gd_sel.sv
module idct_gd_sel
    import idct_gd_pkg::*;
#(
    parameter int ACC_W = 23,
    parameter int OUT_W = 16
) (
    input  quality_e                q,
    input  logic signed [ACC_W-1:0] t1,
    input  logic signed [ACC_W-1:0] t2e,
    input  logic signed [ACC_W-1:0] t2o,
    input  logic signed [ACC_W-1:0] t3e,
    input  logic signed [ACC_W-1:0] t3o,
    output logic signed [OUT_W-1:0] near_w,
    output logic signed [OUT_W-1:0] far_w
);

    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

    logic signed [ACC_W-1:0] sn;
    logic signed [ACC_W-1:0] sf;
    logic signed [ACC_W-1:0] rn;
    logic signed [ACC_W-1:0] rf;

    always_comb begin
        unique case (q)
            Q_FULL: begin
                sn = t1 + t2e + t2o + t3e + t3o;
                sf = t1 + t2e - t2o + t3e - t3o;
            end
            Q_MID: begin
                sn = t1 + t2e + t2o;
                sf = t1 + t2e - t2o;
            end
            Q_DC: begin
                sn = t1;
                sf = t1;
            end
            default: begin
                sn = t1;
                sf = t1;
            end
        endcase
    end

    assign rn     = (sn + RND) >>> FRAC_W;
    assign rf     = (sf + RND) >>> FRAC_W;
    assign near_w = OUT_W'(rn);
    assign far_w  = OUT_W'(rf);

endmodule

// File: rtl/idct_gd_top.sv
module idct_gd_top
    import idct_gd_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [NPT*IN_W-1:0]                      in_coef,
    input  logic                                     drop_hi,
    input  logic                                     dc_only,
    output logic                                     out_valid,
    output logic [NPT*(IN_W+COEF_W+3-FRAC_W)-1:0]    out_pix
);

    localparam int ACC_W = IN_W + COEF_W + 3;
    localparam int OUT_W = ACC_W - FRAC_W;

    logic                  s1_valid;
    logic [NPT*IN_W-1:0]   s1_z;
    quality_e              s1_q;
    quality_e              q_next;
    logic signed [OUT_W-1:0] res [NPT];
    logic [NPT*OUT_W-1:0]  pix_next;

    always_comb begin
        unique case ({dc_only, drop_hi})
            2'b00:   q_next = Q_FULL;
            2'b01:   q_next = Q_MID;
            2'b10,
            2'b11:   q_next = Q_DC;
            default: q_next = Q_DC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_z     <= '0;
            s1_q     <= Q_FULL;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_z <= in_coef;
                s1_q <= q_next;
            end
        end
    end

    for (genvar i = 0; i < HALF; i++) begin : g_pair
        logic signed [ACC_W-1:0] t1, t2e, t2o, t3e, t3o;

        idct_gd_lane #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W),
            .IDX   (i)
        ) u_lane (
            .z   (s1_z),
            .t1  (t1),
            .t2e (t2e),
            .t2o (t2o),
            .t3e (t3e),
            .t3o (t3o)
        );

        idct_gd_sel #(
            .ACC_W (ACC_W),
            .OUT_W (OUT_W)
        ) u_sel (
            .q      (s1_q),
            .t1     (t1),
            .t2e    (t2e),
            .t2o    (t2o),
            .t3e    (t3e),
            .t3o    (t3o),
            .near_w (res[i]),
            .far_w  (res[NPT-1-i])
        );
    end

    always_comb begin
        for (int i = 0; i < NPT; i++) begin
            pix_next[i*OUT_W +: OUT_W] = res[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_pix <= pix_next;
            end
        end
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(s1_valid));

    // R7
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s1_valid) |-> $stable(out_pix));

    // R5
    dc_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_q) == Q_DC) |-> (out_pix == {NPT{out_pix[OUT_W-1:0]}}));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(s1_q));

endmodule

// File: tb/idct_gd_top_test.sv
module idct_gd_top_test;
    import idct_gd_pkg::*;

    localparam int IN_W  = 12;
    localparam int OUT_W = IN_W + COEF_W + 3 - FRAC_W;
    localparam int NV    = 15;

    // Basis as stated in R3, rows w0..w7, columns z0..z7.
    localparam int BASIS [8][8] = '{
        '{45,  64,  60,  52,  45,  36,  25,  12},
        '{45,  52,  25, -12, -45, -64, -60, -36},
        '{45,  36, -25, -64, -45,  12,  60,  52},
        '{45,  12, -60, -36,  45,  52, -25, -64},
        '{45, -12, -60,  36,  45, -52, -25,  64},
        '{45, -36, -25,  64, -45, -12,  60, -52},
        '{45, -52,  25,  12, -45,  64, -60,  36},
        '{45, -64,  60, -52,  45, -36,  25, -12}
    };

    localparam int STIM_Z [NV][8] = '{
        '{128, 0, 0, 0, 0, 0, 0, 0},
        '{0, 128, 0, 0, 0, 0, 0, 0},
        '{0, 0, 128, 0, 0, 0, 0, 0},
        '{0, 0, 0, 128, 0, 0, 0, 0},
        '{0, 0, 0, 0, 128, 0, 0, 0},
        '{0, 0, 0, 0, 0, 128, 0, 0},
        '{0, 0, 0, 0, 0, 0, 128, 0},
        '{0, 0, 0, 0, 0, 0, 0, 128},
        '{100, -200, 300, -400, 500, -600, 700, -800},
        '{100, -200, 300, -400, 500, -600, 700, -800},
        '{100, -200, 300, -400, 500, -600, 700, -800},
        '{100, -200, 300, -400, 500, -600, 700, -800},
        '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047},
        '{-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047},
        '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048}
    };

    // {dc_only, drop_hi}
    localparam logic [1:0] STIM_Q [NV] = '{
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
        2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b00, 2'b01
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic [8*IN_W-1:0]      in_coef = '0;
    logic                   drop_hi = 1'b0;
    logic                   dc_only = 1'b0;
    logic                   out_valid;
    logic [8*OUT_W-1:0]     out_pix;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    idct_gd_top #(.IN_W(IN_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_coef   (in_coef),
        .drop_hi   (drop_hi),
        .dc_only   (dc_only),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    function automatic int model(input int z [8], input int i, input logic drop, input logic dc);
        int s;
        s = 0;
        for (int k = 0; k < 8; k++) begin
            if (k == 0 || (!dc && (k < 5 || !drop))) s += BASIS[i][k] * z[k];
        end
        return (s + 64) >>> 7;
    endfunction

    function automatic int lane(input int i);
        return int'($signed(out_pix[i*OUT_W +: OUT_W]));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int z [8], input logic drop, input logic dc);
        for (int k = 0; k < 8; k++) in_coef[k*IN_W +: IN_W] = IN_W'(z[k]);
        drop_hi  = drop;
        dc_only  = dc;
        in_valid = 1'b1;
    endtask

    task automatic run_one(input int z [8], input logic drop, input logic dc);
        @(negedge clk);
        drive(z, drop, dc);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int zz [8];
        logic [8*OUT_W-1:0] held;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid during reset", int'(out_valid), 0);
        chk("R1 out_pix nonzero during reset", (out_pix == '0) ? 0 : 1, 0);
        rst_n = 1'b1;

        // Table walk, one vector per cycle (R2 throughput, R3/R4/R5, R8)
        for (int c = 0; c < NV + 2; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                int j;
                string tag;
                j = c - 2;
                for (int k = 0; k < 8; k++) zz[k] = STIM_Z[j][k];
                tag = STIM_Q[j][1] ? "R5" : (STIM_Q[j][0] ? "R4" : "R3");
                if (j >= 9 && j <= 11) tag = {tag, " R8"};
                chk($sformatf("R2 out_valid vec %0d", j), int'(out_valid), 1);
                for (int i = 0; i < 8; i++) begin
                    chk($sformatf("%s vec %0d w%0d", tag, j, i), lane(i),
                        model(zz, i, STIM_Q[j][0], STIM_Q[j][1]));
                end
            end
            if (c < NV) begin
                for (int k = 0; k < 8; k++) zz[k] = STIM_Z[c][k];
                drive(zz, STIM_Q[c][0], STIM_Q[c][1]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 out_valid drops after stream", int'(out_valid), 0);

        // R7: quiet inputs do not disturb the outputs
        held     = out_pix;
        in_coef  = {8{12'h5A5}};
        drop_hi  = 1'b1;
        dc_only  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 out_pix changed while idle", (out_pix == held) ? 0 : 1, 0);
        chk("R7 out_valid while idle", int'(out_valid), 0);

        // R2: single-vector latency and pulse width
        zz = '{128, 0, 0, 0, 0, 0, 0, 0};
        @(negedge clk);
        drive(zz, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 out_valid one edge after capture", int'(out_valid), 0);
        @(negedge clk);
        chk("R2 out_valid two edges after capture", int'(out_valid), 1);
        chk("R2 w0 after latency", lane(0), 45);
        @(negedge clk);
        chk("R2 out_valid pulse width", int'(out_valid), 0);

        // R6: rounding ties and small values
        zz = '{0, 1, 0, 0, 0, 0, 0, 0};
        run_one(zz, 1'b0, 1'b0);
        chk("R6 z1=+1 w0 (+0.5)", lane(0), 1);
        chk("R6 z1=+1 w7 (-0.5)", lane(7), 0);
        zz = '{0, -1, 0, 0, 0, 0, 0, 0};
        run_one(zz, 1'b0, 1'b0);
        chk("R6 z1=-1 w0 (-0.5)", lane(0), 0);
        chk("R6 z1=-1 w7 (+0.5)", lane(7), 1);
        zz = '{2, 0, 0, 0, 0, 0, 0, 0};
        run_one(zz, 1'b0, 1'b0);
        chk("R6 z0=+2 w3", lane(3), 1);
        zz = '{-2, 0, 0, 0, 0, 0, 0, 0};
        run_one(zz, 1'b0, 1'b0);
        chk("R6 z0=-2 w5", lane(5), -1);
        zz = '{1, 0, 0, 0, 0, 0, 0, 0};
        run_one(zz, 1'b0, 1'b0);
        chk("R6 z0=+1 w0", lane(0), 0);

        // R5: DC state with a full-scale vector, drop bit also set
        zz = '{-2048, 2047, 2047, 2047, 2047, 2047, 2047, 2047};
        run_one(zz, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) chk($sformatf("R5 dc full scale w%0d", i), lane(i), -720);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: got no completion expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule